// File: doc/BRIEF.md
# Bus-Master DMA Burst Length Limiter

This block governs how long a bus master holds the bus for one FIFO DMA burst. A burst request names a direction: a read burst fills the transmit FIFO, and a write burst drains the receive FIFO. The block raises a bus request and waits for grant. It then stays in the owning state until a stop condition appears. When that happens it emits a one-cycle end pulse and a 2-bit code that names the cause. The bus interface uses `bus_req` to keep requesting and `burst_active` to keep issuing transfers. It reports each finished transfer back on `xfer_done`.

The block has two termination policies, selected by `cfg_mode`.
- **Count-limited (`cfg_mode` = 0).** A transfer counter caps the burst at a programmable number of transfers. The FIFO watermarks and an activity timer can still end the burst earlier.
- **Watermark- or timer-limited (`cfg_mode` = 1).** The counter is disabled. The burst runs until the FIFO watermark for its direction is reached, or until the activity timer runs out.

If grant is taken away mid-burst, the master keeps the bus until the latency timer expires. It then gives up the bus with a latency end code and re-requests at once. The transfer count stays frozen across the gap, while the activity timer is reloaded when the bus is regained.

Top module: `burst_len_limiter`

## Requirements
- R1: After a synchronous reset, `bus_req`, `burst_active` and `burst_end` are 0, `xfer_count` is 0, `end_reason` is 0, and the internal transfer limit holds 16.
- R2: In idle, `dma_req` latches `dma_dir` (0 = read/transmit fill, 1 = write/receive drain) and clears `xfer_count`; `bus_req` is 1 from the next cycle. A `bus_grant` seen while requesting drops `bus_req` and raises `burst_active` on the next cycle.
- R3: With `cfg_mode` = 0, each `xfer_done` seen while `burst_active` adds one to `xfer_count`. The transfer that brings the count to the limit ends the burst: on the next cycle `burst_end` = 1, `end_reason` = 0 (count) and `burst_active` = 0. The limit defaults to 16, and a cycle with `limit_we` = 1 loads `limit_wdata` into it.
- R4: A programmed limit of 0 acts as a limit of 1.
- R5: In either mode, a read burst ends with `end_reason` = 1 (watermark) when `tx_level` >= `tx_high_wm`, and a write burst ends with code 1 when `rx_level` <= `rx_low_wm`. The comparison is made on any owned cycle.
- R6: The activity timer loads `cfg_timer_start` when grant is taken. It then decrements once per owned cycle. An owned cycle that finds it at zero ends the burst with `end_reason` = 2 (timer), so with start value T and no other cause, `burst_end` follows T+1 owned cycles after the grant edge.
- R7: With `cfg_mode` = 1, `xfer_count` does not change on `xfer_done`, and no burst ends with the count code.
- R8: A `preempt` pulse while owning keeps `burst_active` high, with transfers still counted, until `lat_expired`. The burst then ends with `end_reason` = 3 (latency), and `bus_req` is 1 on the same cycle as that `burst_end`.
- R9: While re-requesting after a latency end, `xfer_count` holds its value, and counting resumes from it after the new grant. The activity timer restarts from `cfg_timer_start` at the new grant.
- R10: When several stop causes hit in one cycle, the code reported is the highest in the order count, watermark, timer, latency.
- R11: `burst_end` is never high on two consecutive cycles, and `bus_req` and `burst_active` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 1 | 0 = count-limited, 1 = watermark/timer-limited |
| limit_we | input | 1 | Load strobe for the transfer limit |
| limit_wdata | input | CNT_W | New transfer limit |
| cfg_timer_start | input | TMR_W | Activity timer start value |
| dma_req | input | 1 | Request to start a burst (taken in idle) |
| dma_dir | input | 1 | 0 = read (fills transmit FIFO), 1 = write (drains receive FIFO) |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| tx_high_wm | input | LVL_W | Transmit FIFO high watermark |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_low_wm | input | LVL_W | Receive FIFO low watermark |
| xfer_done | input | 1 | One bus transfer completed |
| bus_grant | input | 1 | Bus granted to this master |
| preempt | input | 1 | Grant withdrawn during a burst |
| lat_expired | input | 1 | Latency timer has expired |
| bus_req | output | 1 | Keep requesting the bus |
| burst_active | output | 1 | Bus owned, keep bursting |
| burst_end | output | 1 | One-cycle end-of-mastership pulse |
| end_reason | output | 2 | 0 count, 1 watermark, 2 timer, 3 latency |
| xfer_count | output | CNT_W | Transfers counted in the current burst |

## Verification
A corrupted transfer count shows up at `xfer_count` on the following cycle. Soon after, it also shows as a burst that ends one transfer early or late under a count code. A timer loaded or decremented wrongly moves the timer end pulse by whole cycles away from T+1 after grant. A count that is not frozen during the preemption gap makes `xfer_count` drift while `bus_req` is high. A wrong state register shows at once as `bus_req` and `burst_active` disagreeing with the cycle-by-cycle model. Every output is compared on every clock, so any such fault is seen within one cycle of reaching a port.

// File: rtl/blim_pkg.sv
package blim_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_OWN  = 2'd2,
    ST_HOLD = 2'd3
  } blim_state_e;

  typedef enum logic [1:0] {
    RSN_COUNT   = 2'd0,
    RSN_WMARK   = 2'd1,
    RSN_TIMER   = 2'd2,
    RSN_LATENCY = 2'd3
  } blim_reason_e;
endpackage

// File: rtl/blim_xfer_counter.sv
module blim_xfer_counter #(
  parameter int CNT_W         = 8,
  parameter int DEFAULT_LIMIT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             limit_we,
  input  logic [CNT_W-1:0] limit_wdata,
  input  logic             clear,
  input  logic             step,
  input  logic             count_en,
  output logic [CNT_W-1:0] count,
  output logic             limit_hit
);
  localparam logic [CNT_W-1:0] RST_LIMIT = CNT_W'(DEFAULT_LIMIT);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] eff_limit;
  logic [CNT_W:0]   cnt_after;

  always_ff @(posedge clk) begin
    if (rst) limit_q <= RST_LIMIT;
    else if (limit_we) limit_q <= limit_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (step) cnt_q <= cnt_q + ONE;
  end

  always_comb begin
    eff_limit = (limit_q == '0) ? ONE : limit_q;
    cnt_after = {1'b0, cnt_q} + {{CNT_W{1'b0}}, step};
    limit_hit = count_en && (cnt_after >= {1'b0, eff_limit});
  end

  assign count = cnt_q;
endmodule

// File: rtl/blim_activity_timer.sv
module blim_activity_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reload,
  input  logic [TMR_W-1:0] start_val,
  input  logic             run,
  output logic             expired
);
  logic [TMR_W-1:0] tmr_q;

  always_ff @(posedge clk) begin
    if (rst) tmr_q <= '0;
    else if (reload) tmr_q <= start_val;
    else if (run && (tmr_q != '0)) tmr_q <= tmr_q - TMR_W'(1);
  end

  assign expired = (tmr_q == '0);
endmodule

// File: rtl/blim_stop_eval.sv
module blim_stop_eval
  import blim_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic             owning,
  input  logic             dir_write,
  input  logic             count_hit,
  input  logic             timer_hit,
  input  logic             latency_hit,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] tx_high_wm,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_low_wm,
  output logic             stop,
  output logic             latency_only,
  output blim_reason_e     reason
);
  logic wmark_hit;

  always_comb begin
    wmark_hit = dir_write ? (rx_level <= rx_low_wm) : (tx_level >= tx_high_wm);
    reason    = RSN_LATENCY;
    if (count_hit)      reason = RSN_COUNT;
    else if (wmark_hit) reason = RSN_WMARK;
    else if (timer_hit) reason = RSN_TIMER;
    stop         = owning && (count_hit || wmark_hit || timer_hit || latency_hit);
    latency_only = !(count_hit || wmark_hit || timer_hit);
  end
endmodule

// File: rtl/burst_len_limiter.sv
module burst_len_limiter
  import blim_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int TMR_W         = 8,
  parameter int LVL_W         = 6,
  parameter int DEFAULT_LIMIT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_mode,
  input  logic             limit_we,
  input  logic [CNT_W-1:0] limit_wdata,
  input  logic [TMR_W-1:0] cfg_timer_start,
  input  logic             dma_req,
  input  logic             dma_dir,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] tx_high_wm,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_low_wm,
  input  logic             xfer_done,
  input  logic             bus_grant,
  input  logic             preempt,
  input  logic             lat_expired,
  output logic             bus_req,
  output logic             burst_active,
  output logic             burst_end,
  output logic [1:0]       end_reason,
  output logic [CNT_W-1:0] xfer_count
);
  blim_state_e  state_q;
  logic         dir_q;
  logic         end_q;
  blim_reason_e reason_q;

  logic         owning;
  logic         start_burst;
  logic         take_grant;
  logic         cnt_step;
  logic         cnt_hit;
  logic         tmr_hit;
  logic         lat_hit;
  logic         stop;
  logic         lat_only;
  blim_reason_e stop_reason;

  assign owning      = (state_q == ST_OWN) || (state_q == ST_HOLD);
  assign start_burst = (state_q == ST_IDLE) && dma_req;
  assign take_grant  = (state_q == ST_REQ) && bus_grant;
  assign cnt_step    = owning && xfer_done && !cfg_mode;
  assign lat_hit     = (state_q == ST_HOLD) && lat_expired;

  blim_xfer_counter #(
    .CNT_W(CNT_W),
    .DEFAULT_LIMIT(DEFAULT_LIMIT)
  ) u_counter (
    .clk(clk),
    .rst(rst),
    .limit_we(limit_we),
    .limit_wdata(limit_wdata),
    .clear(start_burst),
    .step(cnt_step),
    .count_en(!cfg_mode),
    .count(xfer_count),
    .limit_hit(cnt_hit)
  );

  blim_activity_timer #(
    .TMR_W(TMR_W)
  ) u_timer (
    .clk(clk),
    .rst(rst),
    .reload(take_grant),
    .start_val(cfg_timer_start),
    .run(owning),
    .expired(tmr_hit)
  );

  blim_stop_eval #(
    .LVL_W(LVL_W)
  ) u_stop (
    .owning(owning),
    .dir_write(dir_q),
    .count_hit(cnt_hit),
    .timer_hit(tmr_hit),
    .latency_hit(lat_hit),
    .tx_level(tx_level),
    .tx_high_wm(tx_high_wm),
    .rx_level(rx_level),
    .rx_low_wm(rx_low_wm),
    .stop(stop),
    .latency_only(lat_only),
    .reason(stop_reason)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      dir_q    <= 1'b0;
      end_q    <= 1'b0;
      reason_q <= RSN_COUNT;
    end else begin
      end_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (dma_req) begin
            dir_q   <= dma_dir;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (bus_grant) state_q <= ST_OWN;
        end
        default: begin
          if (stop) begin
            end_q    <= 1'b1;
            reason_q <= stop_reason;
            state_q  <= lat_only ? ST_REQ : ST_IDLE;
          end else if ((state_q == ST_OWN) && preempt) begin
            state_q <= ST_HOLD;
          end
        end
      endcase
    end
  end

  assign bus_req      = (state_q == ST_REQ);
  assign burst_active = owning;
  assign burst_end    = end_q;
  assign end_reason   = reason_q;
endmodule

// File: rtl/burst_len_limiter_chk.sv
module burst_len_limiter_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_mode,
  input logic             bus_req,
  input logic             burst_active,
  input logic             burst_end,
  input logic [1:0]       end_reason,
  input logic [CNT_W-1:0] xfer_count
);
  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    burst_end |=> !burst_end);

  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && burst_active));

  assert_end_releases_R3: assert property (@(posedge clk) disable iff (rst)
    burst_end |-> !burst_active);

  assert_latency_rerequest_R8: assert property (@(posedge clk) disable iff (rst)
    (burst_end && (end_reason == 2'd3)) |-> bus_req);

  assert_count_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    bus_req |=> $stable(xfer_count));

  assert_mode1_no_count_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode && burst_active) |=> $stable(xfer_count));
endmodule

bind burst_len_limiter burst_len_limiter_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk),
  .rst(rst),
  .cfg_mode(cfg_mode),
  .bus_req(bus_req),
  .burst_active(burst_active),
  .burst_end(burst_end),
  .end_reason(end_reason),
  .xfer_count(xfer_count)
);

// File: tb/burst_len_limiter_tb_top.sv
`timescale 1ns/1ps
module burst_len_limiter_tb_top;
  localparam int CNT_W = 8;
  localparam int TMR_W = 8;
  localparam int LVL_W = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_mode = 1'b0;
  logic limit_we = 1'b0;
  logic [CNT_W-1:0] limit_wdata = '0;
  logic [TMR_W-1:0] cfg_timer_start = 8'd200;
  logic dma_req = 1'b0;
  logic dma_dir = 1'b0;
  logic [LVL_W-1:0] tx_level = '0;
  logic [LVL_W-1:0] tx_high_wm = 6'd63;
  logic [LVL_W-1:0] rx_level = 6'd63;
  logic [LVL_W-1:0] rx_low_wm = '0;
  logic xfer_done = 1'b0;
  logic bus_grant = 1'b0;
  logic preempt = 1'b0;
  logic lat_expired = 1'b0;
  logic bus_req, burst_active, burst_end;
  logic [1:0] end_reason;
  logic [CNT_W-1:0] xfer_count;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  burst_len_limiter #(.CNT_W(CNT_W), .TMR_W(TMR_W), .LVL_W(LVL_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .limit_we(limit_we),
    .limit_wdata(limit_wdata), .cfg_timer_start(cfg_timer_start),
    .dma_req(dma_req), .dma_dir(dma_dir), .tx_level(tx_level),
    .tx_high_wm(tx_high_wm), .rx_level(rx_level), .rx_low_wm(rx_low_wm),
    .xfer_done(xfer_done), .bus_grant(bus_grant), .preempt(preempt),
    .lat_expired(lat_expired), .bus_req(bus_req), .burst_active(burst_active),
    .burst_end(burst_end), .end_reason(end_reason), .xfer_count(xfer_count));

  // Reference model: 0 idle, 1 requesting, 2 owning, 3 owning after preemption
  int m_phase, m_cnt, m_tmr, m_lim, m_dir, m_end, m_reason;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_cnt = 0; m_tmr = 0; m_lim = 16; m_dir = 0; m_end = 0; m_reason = 0;
    end else begin
      int new_lim;
      new_lim = limit_we ? int'(limit_wdata) : m_lim;
      m_end = 0;
      if (m_phase == 0) begin
        if (dma_req) begin m_dir = int'(dma_dir); m_cnt = 0; m_phase = 1; end
      end else if (m_phase == 1) begin
        if (bus_grant) begin m_tmr = int'(cfg_timer_start); m_phase = 2; end
      end else begin
        int c, lim_eff;
        bit by_cnt, by_wm, by_tmr, by_lat;
        c = m_cnt + ((xfer_done && !cfg_mode) ? 1 : 0);
        lim_eff = (m_lim == 0) ? 1 : m_lim;
        by_cnt = !cfg_mode && (c >= lim_eff);
        by_wm  = (m_dir == 1) ? (rx_level <= rx_low_wm) : (tx_level >= tx_high_wm);
        by_tmr = (m_tmr == 0);
        by_lat = (m_phase == 3) && lat_expired;
        m_cnt = c;
        if (by_cnt || by_wm || by_tmr || by_lat) begin
          m_end = 1;
          m_reason = by_cnt ? 0 : by_wm ? 1 : by_tmr ? 2 : 3;
          m_phase = (m_reason == 3) ? 1 : 0;
        end else if (m_phase == 2 && preempt) begin
          m_phase = 3;
        end
        if (m_tmr > 0) m_tmr = m_tmr - 1;
      end
      m_lim = new_lim;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk("R2 bus_req", int'(bus_req), (m_phase == 1) ? 1 : 0);
      chk("R8 burst_active", int'(burst_active), (m_phase >= 2) ? 1 : 0);
      chk("R9 xfer_count", int'(xfer_count), m_cnt);
      chk("R11 burst_end", int'(burst_end), m_end);
      chk("R10 end_reason", int'(end_reason), m_reason);
    end
    if (cycles > 100000) begin
      failures++;
      $display("FAIL R2 watchdog actual=%0d expected<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_limit(input int v);
    @(negedge clk); limit_we = 1'b1; limit_wdata = CNT_W'(v);
    @(negedge clk); limit_we = 1'b0;
  endtask

  task automatic launch(input bit dir);
    @(negedge clk); dma_req = 1'b1; dma_dir = dir;
    @(negedge clk); dma_req = 1'b0;
  endtask

  task automatic wait_end(input int exp_reason, input int exp_cnt, input string tag,
                          output int waited);
    waited = 0;
    while (!burst_end && waited < 400) begin
      @(negedge clk);
      waited++;
    end
    chk({tag, " end pulse"}, int'(burst_end), 1);
    chk({tag, " reason"}, int'(end_reason), exp_reason);
    if (exp_cnt >= 0) chk({tag, " count"}, int'(xfer_count), exp_cnt);
  endtask

  initial begin
    int w, held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset bus_req", int'(bus_req), 0);
    chk("R1 reset burst_active", int'(burst_active), 0);
    chk("R1 reset burst_end", int'(burst_end), 0);
    chk("R1 reset xfer_count", int'(xfer_count), 0);

    // R1/R3: default limit of 16 ends the burst by count
    bus_grant = 1'b1; xfer_done = 1'b1;
    launch(1'b0);
    wait_end(0, 16, "R3 default limit", w);
    chk("R3 released after end", int'(burst_active), 0);
    step_n(2);

    // R4: limit 0 acts as 1
    write_limit(0);
    launch(1'b0);
    wait_end(0, 1, "R4 zero limit", w);
    step_n(2);

    // R5: read watermark reached on the first owned cycle
    write_limit(5);
    tx_high_wm = 6'd10; tx_level = 6'd10;
    launch(1'b0);
    wait_end(1, 1, "R5 tx watermark", w);
    tx_level = '0; tx_high_wm = 6'd63;
    step_n(2);

    // R5: write watermark, no transfers
    xfer_done = 1'b0; rx_level = 6'd2; rx_low_wm = 6'd3;
    launch(1'b1);
    wait_end(1, 0, "R5 rx watermark", w);
    rx_level = 6'd63; rx_low_wm = '0;
    step_n(2);

    // R6: timer with start 3
    cfg_timer_start = 8'd3;
    launch(1'b0);
    wait_end(2, 0, "R6 timer", w);
    step_n(2);

    // R7: mode 1 ignores transfers, ends on timer
    cfg_mode = 1'b1; xfer_done = 1'b1; cfg_timer_start = 8'd20;
    launch(1'b0);
    wait_end(2, 0, "R7 mode1 count held", w);
    cfg_mode = 1'b0;
    step_n(2);

    // R10: count, watermark and timer in the same cycle
    write_limit(1);
    cfg_timer_start = 8'd0; tx_level = 6'd63;
    launch(1'b0);
    wait_end(0, 1, "R10 priority", w);
    tx_level = '0; cfg_timer_start = 8'd50;
    step_n(2);

    // R8/R9: preemption, latency end, frozen count, resume
    write_limit(10);
    launch(1'b0);
    step_n(3);
    preempt = 1'b1; bus_grant = 1'b0;
    @(negedge clk); preempt = 1'b0;
    step_n(2);
    chk("R8 still owning after preempt", int'(burst_active), 1);
    lat_expired = 1'b1;
    @(negedge clk); lat_expired = 1'b0;
    wait_end(3, -1, "R8 latency", w);
    chk("R8 re-request", int'(bus_req), 1);
    held = int'(xfer_count);
    step_n(3);
    chk("R9 count frozen while waiting", int'(xfer_count), held);
    bus_grant = 1'b1;
    step_n(1);
    wait_end(0, 10, "R9 resumed count", w);
    step_n(2);

    // R9/R6: timer reload on regrant, start 6 -> end 8 negedges after grant
    write_limit(200);
    xfer_done = 1'b0; cfg_timer_start = 8'd6;
    launch(1'b0);
    step_n(2);
    preempt = 1'b1; bus_grant = 1'b0;
    @(negedge clk); preempt = 1'b0; lat_expired = 1'b1;
    @(negedge clk); lat_expired = 1'b0;
    wait_end(3, 0, "R9 latency before reload", w);
    step_n(2);
    bus_grant = 1'b1;
    wait_end(2, 0, "R9 timer reloaded", w);
    chk("R6 timer span after regrant", w, 8);
    step_n(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule